// File: doc/BRIEF.md
# Bitmask Immediate Encoder

This block decides whether a 64-bit or 32-bit constant can be expressed as a single contiguous run of ones. That run sits inside an element of 2, 4, 8, 16, 32 or 64 bits, is rotated within the element, and the element is repeated across the word. When the constant has this shape, the block returns the three fields that describe it: a size bit, a six-bit length/size code and a six-bit rotation. A code generator uses it to choose between a compact immediate form and a longer fallback sequence.

The block is a fixed two-stage pipeline and accepts one operand per cycle. A zero-bubble stream of operands can be fed to it. The first stage normalises the operand: it inverts a value whose bit 0 is set, and it doubles a 32-bit operand up to 64 bits. The same stage then isolates three lowest set bits and counts their leading zeros. The second stage derives the repeat period and rebuilds the only pattern the operand could be. It compares that pattern with the normalised operand and forms the fields.

Top module: `bmi_encoder`

## Requirements
- R1: A result appears on `out_valid` exactly two clock edges after the operand was presented with `in_valid` high. Reset clears `out_valid` and all result outputs.
- R2: An operand whose selected width is all zeros or all ones is reported with `out_ok` low.
- R3: Whenever `out_valid` is high and `out_ok` is low, `out_n`, `out_imms` and `out_immr` are all zero.
- R4: In 64-bit mode (`in_wide`=1), a word that is a repeated element of size e, with e ones rotated right by t (1 ≤ e < element size, 0 ≤ t < element size), is encoded canonically. For a 64-bit element: out_n=1 and out_imms=e-1. For smaller elements: out_n=0 and out_imms = (~(2·size−1) & 0x3F) | (e−1), so that the highest zero bit of out_imms marks the size. In both cases out_immr=t.
- R5: In 32-bit mode (`in_wide`=0), only bits 31:0 of `in_value` are examined and bits 63:32 have no effect. Elements are at most 32 bits, so out_n is always 0, and the fields follow R4.
- R6: Operands with bit 0 set, whose run of ones wraps across bit 0 of the element, are encoded as in R4 and R5.
- R7: An operand that is not a periodic repetition of a single circular run of ones is reported with `out_ok` low.
- R8: In a cycle where `out_valid` is low, `out_ok`, `out_n`, `out_imms` and `out_immr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_value | input | 64 | Operand; only bits 31:0 used in 32-bit mode |
| in_wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| out_valid | output | 1 | Result present this cycle |
| out_ok | output | 1 | Operand is encodable |
| out_n | output | 1 | Size bit (64-bit element) |
| out_imms | output | 6 | Element size and run length code |
| out_immr | output | 6 | Right rotation within the element |

## Verification
Two steps can act on the same operand in the same cycle: inversion of an operand with bit 0 set, and duplication of the low half in 32-bit mode. In that case the wrapped-run correction must use the period of the doubled word. The bench provokes this by sweeping every legal element size, run length and rotation in 32-bit mode, with random garbage in the upper half. About half of those operands carry bit 0 set. Each result is judged against the triple that produced the operand through an arithmetic decoder in the bench. Random and one-bit-damaged operands are judged against an independent periodic single-run test, and any that are encodable are decoded back for comparison.

// File: rtl/bmi_pkg.sv
// Shared widths, types and helper functions for the bitmask immediate encoder.
// Assumes a 64-bit word; the narrow mode is half of it.
package bmi_pkg;
    localparam int WORD_W = 64;
    localparam int LOG_W  = $clog2(WORD_W);
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = LOG_W + 3;   // signed room for -1 .. 2*WORD_W
    localparam int FLD_W  = LOG_W;

    typedef logic [WORD_W-1:0]       word_t;
    typedef logic signed [CNT_W-1:0] cnt_t;

    // Stage-1 result carried to the field stage.
    typedef struct packed {
        word_t v;       // normalised operand
        logic  neg;     // operand was inverted
        word_t a;       // lowest set bit of v
        word_t b;       // lowest set bit of v + a
        logic  c_nz;    // a second run exists
        cnt_t  clz_a;
        cnt_t  clz_b;   // -1 when b is zero
        cnt_t  clz_c;
    } run_t;

    // Isolate the lowest set bit (zero for a zero word).
    function automatic word_t lowest_one(input word_t x);
        return x & (~x + word_t'(1));
    endfunction

    // Leading-zero count; WORD_W for a zero word.
    function automatic cnt_t lead_zeros(input word_t x);
        cnt_t r;
        r = cnt_t'(WORD_W);
        for (int i = 0; i < WORD_W; i++) begin
            if (x[i]) r = cnt_t'(WORD_W - 1 - i);
        end
        return r;
    endfunction
endpackage

// File: rtl/bmi_prep.sv
// Operand normalisation. Inverts a value whose bit 0 is set so that no run
// wraps across bit 0, then in narrow mode duplicates the low half into a full
// word. Purely combinational. Assumes the upper half is don't-care in narrow mode.
module bmi_prep
    import bmi_pkg::*;
(
    input  word_t raw,
    input  logic  wide,
    output word_t v,
    output logic  neg
);
    word_t flipped;

    // Invert on bit 0, then widen narrow operands by duplication.
    always_comb begin
        neg     = raw[0];
        flipped = raw[0] ? ~raw : raw;
        v       = wide ? flipped : {flipped[HALF_W-1:0], flipped[HALF_W-1:0]};
    end
endmodule

// File: rtl/bmi_runfind.sv
// Run locator. Finds the lowest set bit a, the bit b just above the lowest
// run (via v + a), and the lowest set bit c of the next run (via v + a - b),
// plus their leading-zero counts. Assumes v has bit 0 clear.
module bmi_runfind
    import bmi_pkg::*;
(
    input  word_t v,
    input  logic  neg,
    output run_t  run
);
    word_t a, b, c, sum_a, rest;

    // Lowest-set-bit isolation steps and leading-zero counts.
    always_comb begin
        a        = lowest_one(v);
        sum_a    = v + a;
        b        = lowest_one(sum_a);
        rest     = sum_a - b;
        c        = lowest_one(rest);
        run.v    = v;
        run.neg  = neg;
        run.a    = a;
        run.b    = b;
        run.c_nz = (c != '0);
        run.clz_a = lead_zeros(a);
        run.clz_b = (b == '0) ? cnt_t'(-1) : lead_zeros(b);
        run.clz_c = lead_zeros(c);
    end
endmodule

// File: rtl/bmi_fields.sv
// Period check, candidate rebuild and field formation. The candidate for each
// legal element size is built by replicating the low bits of (b - a); the one
// matching the derived period is compared with the operand. Fields are forced
// to zero when the operand is not encodable. Purely combinational.
module bmi_fields
    import bmi_pkg::*;
(
    input  run_t             run,
    output logic             ok,
    output logic             n_bit,
    output logic [FLD_W-1:0] imms,
    output logic [FLD_W-1:0] immr
);
    localparam int NSIZE = LOG_W;

    word_t diff;
    word_t cand_by_size [NSIZE];

    assign diff = run.b - run.a;

    // One replicated candidate per element size 2 .. WORD_W.
    generate
        for (genvar k = 0; k < NSIZE; k++) begin : g_rep
            localparam int ESZ = 2 << k;
            assign cand_by_size[k] = {(WORD_W / ESZ){diff[ESZ-1:0]}};
        end
    endgenerate

    cnt_t  d, s, r, code;
    logic  n_raw, d_pow2, fit, match;
    word_t mask, cand;

    // Derive period, validate, and encode the run length and rotation.
    always_comb begin
        if (run.c_nz) begin
            d     = run.clz_a - run.clz_c;
            n_raw = 1'b0;
        end else begin
            d     = cnt_t'(WORD_W);
            n_raw = 1'b1;
        end
        d_pow2 = (d > 0) && ((d & (d - cnt_t'(1))) == '0);
        mask   = '1;
        if (d < cnt_t'(WORD_W)) mask = ~({WORD_W{1'b1}} << d[LOG_W-1:0]);
        fit    = ((diff & ~mask) == '0);
        cand   = '0;
        for (int k = 0; k < NSIZE; k++) begin
            if (d == cnt_t'(2 << k)) cand = cand_by_size[k];
        end
        match  = (cand == run.v);
        s      = run.clz_a - run.clz_b;
        if (run.neg) begin
            s = d - s;
            r = (run.clz_b + cnt_t'(1)) & (d - cnt_t'(1));
        end else begin
            r = (run.clz_a + cnt_t'(1)) & (d - cnt_t'(1));
        end
        code  = ((-d) <<< 1) | (s - cnt_t'(1));
        ok    = (run.a != '0) && d_pow2 && fit && match;
        n_bit = ok ? n_raw : 1'b0;
        imms  = ok ? code[FLD_W-1:0] : '0;
        immr  = ok ? r[FLD_W-1:0] : '0;
    end
endmodule

// File: rtl/bmi_encoder.sv
// Bitmask immediate encoder, top level. Two register stages: the first holds
// the normalised operand and run positions, the second holds the result.
// Latency is two clock edges; one operand per cycle. Synchronous active-low reset.
module bmi_encoder
    import bmi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     in_value,
    input  logic                  in_wide,
    output logic                  out_valid,
    output logic                  out_ok,
    output logic                  out_n,
    output logic [FLD_W-1:0]      out_imms,
    output logic [FLD_W-1:0]      out_immr
);
    word_t            norm_v;
    logic             norm_neg;
    run_t             run_c, s1_run;
    logic             s1_valid, s1_wide, out_wide_q;
    logic             f_ok, f_n;
    logic [FLD_W-1:0] f_imms, f_immr;

    bmi_prep u_prep (
        .raw  (in_value),
        .wide (in_wide),
        .v    (norm_v),
        .neg  (norm_neg)
    );

    bmi_runfind u_runfind (
        .v   (norm_v),
        .neg (norm_neg),
        .run (run_c)
    );

    bmi_fields u_fields (
        .run   (s1_run),
        .ok    (f_ok),
        .n_bit (f_n),
        .imms  (f_imms),
        .immr  (f_immr)
    );

    // Stage 1: capture run positions of the accepted operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_wide  <= 1'b0;
            s1_run   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_wide <= in_wide;
                s1_run  <= run_c;
            end
        end
    end

    // Stage 2: register the result, zero when no operand is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_ok     <= 1'b0;
            out_n      <= 1'b0;
            out_imms   <= '0;
            out_immr   <= '0;
            out_wide_q <= 1'b0;
        end else begin
            out_valid  <= s1_valid;
            out_ok     <= s1_valid && f_ok;
            out_n      <= s1_valid && f_n;
            out_imms   <= s1_valid ? f_imms : '0;
            out_immr   <= s1_valid ? f_immr : '0;
            out_wide_q <= s1_wide;
        end
    end

    // R1: an accepted operand fills stage 1 on the next edge.
    a_r1_stage_fill: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    // R1: stage 1 content reaches the output on the next edge.
    a_r1_out_follow: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R1: no result appears without an operand in stage 1.
    a_r1_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    // R2: an empty (all-zero after normalisation) operand is rejected.
    a_r2_empty_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_run.a == '0) |=> (out_valid && !out_ok));
    // R3: rejected results carry zero fields.
    a_r3_reject_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ok) |-> (!out_n && out_imms == '0 && out_immr == '0));
    // R8: idle cycles carry zero outputs.
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ok && !out_n && out_imms == '0 && out_immr == '0));
    // R5: narrow mode never yields a full-word element.
    a_r5_narrow_no_n: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ok && !out_wide_q) |-> !out_n);
    // R4: a sub-word element never has the reserved all-ones size code.
    a_r4_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ok && !out_n) |-> (out_imms[FLD_W-1:1] != '1));
    // R4: a full-word element never has 64 ones.
    a_r4_full_not_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ok && out_n) |-> (out_imms != '1));
endmodule

// File: tb/bmi_encoder_bench.sv
`timescale 1ns/100ps
module bmi_encoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_value = '0;
    logic        in_wide = 1'b1;
    logic        out_valid, out_ok, out_n;
    logic [5:0]  out_imms, out_immr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    bmi_encoder u_bmi_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_wide(in_wide), .out_valid(out_valid), .out_ok(out_ok),
        .out_n(out_n), .out_imms(out_imms), .out_immr(out_immr)
    );

    // Expected-result slots: [0] just driven, [1] due at the next sample.
    logic        q_iv [2];
    logic        q_ok [2];
    logic        q_n  [2];
    logic        q_w  [2];
    logic        q_rt [2];
    logic [5:0]  q_s  [2];
    logic [5:0]  q_r  [2];
    logic [63:0] q_val[2];
    string       q_tag[2];

    task automatic chk(input bit cond, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Arithmetic decoder of a field triple into its 64-bit pattern.
    function automatic logic [63:0] decode(input logic nb, input logic [5:0] imms,
                                           input logic [5:0] immr);
        int len, esz, sv, rv;
        logic [6:0]  key;
        logic [63:0] elem, rot, res;
        len = -1;
        key = {nb, ~imms};
        for (int i = 0; i < 7; i++) if (key[i]) len = i;
        if (len < 1) return '0;
        esz = 1 << len;
        sv  = int'(imms) & (esz - 1);
        rv  = int'(immr) & (esz - 1);
        elem = '0;
        for (int i = 0; i <= sv; i++) elem[i] = 1'b1;
        rot = '0;
        for (int i = 0; i < esz; i++) rot[i] = elem[(i + rv) % esz];
        res = '0;
        for (int i = 0; i < 64; i++) res[i] = rot[i % esz];
        return res;
    endfunction

    // Independent encodability test: periodic single circular run.
    function automatic bit is_enc(input logic [63:0] val, input bit wide);
        int w, t;
        bit per;
        w = wide ? 64 : 32;
        for (int e = 2; e <= w; e = e * 2) begin
            per = 1;
            for (int i = 0; i < w; i++) if (val[i] != val[i % e]) per = 0;
            if (per) begin
                t = 0;
                for (int i = 0; i < e; i++) if (val[i] != val[(i + 1) % e]) t++;
                if (t == 2) return 1;
            end
        end
        return 0;
    endfunction

    task automatic check_due();
        logic [63:0] back, msk;
        if (!q_iv[1]) begin
            chk(!out_valid && !out_ok && !out_n && out_imms == 0 && out_immr == 0,
                "R8", "idle outputs", {out_valid, out_ok, out_n, out_imms, out_immr}, 64'h0);
        end else begin
            chk(out_valid, "R1", "out_valid latency", 64'(out_valid), 64'h1);
            if (q_rt[1] && q_ok[1]) begin
                msk  = q_w[1] ? '1 : 64'h0000_0000_FFFF_FFFF;
                back = decode(out_n, out_imms, out_immr);
                chk(out_ok && ((back & msk) == (q_val[1] & msk)), q_tag[1],
                    "round trip", back & msk, q_val[1] & msk);
            end else begin
                chk(out_ok == q_ok[1] && out_n == q_n[1] && out_imms == q_s[1] &&
                    out_immr == q_r[1], q_tag[1], "fields {ok,n,imms,immr}",
                    {out_ok, out_n, out_imms, out_immr}, {q_ok[1], q_n[1], q_s[1], q_r[1]});
            end
        end
    endtask

    task automatic push(input logic iv, input logic [63:0] val, input logic wide,
                        input logic xok, input logic xn, input logic [5:0] xs,
                        input logic [5:0] xr, input logic rt, input string tag);
        @(negedge clk);
        check_due();
        q_iv[1] = q_iv[0]; q_ok[1] = q_ok[0]; q_n[1] = q_n[0]; q_w[1] = q_w[0];
        q_rt[1] = q_rt[0]; q_s[1] = q_s[0]; q_r[1] = q_r[0]; q_val[1] = q_val[0];
        q_tag[1] = q_tag[0];
        in_valid = iv; in_value = val; in_wide = wide;
        q_iv[0] = iv; q_ok[0] = xok; q_n[0] = xn; q_w[0] = wide; q_rt[0] = rt;
        q_s[0] = xs; q_r[0] = xr; q_val[0] = val; q_tag[0] = tag;
    endtask

    task automatic push_judged(input logic [63:0] val, input bit wide, input string tag);
        bit e;
        e = is_enc(val, wide);
        push(1'b1, val, wide, e, 1'b0, 6'h0, 6'h0, e, e ? "R4" : tag);
    endtask

    initial begin
        int cnt;
        logic [63:0] val;
        logic [5:0]  code;
        bit wide, nb;
        for (int i = 0; i < 2; i++) begin
            q_iv[i] = 0; q_ok[i] = 0; q_n[i] = 0; q_w[i] = 0; q_rt[i] = 0;
            q_s[i] = 0; q_r[i] = 0; q_val[i] = 0; q_tag[i] = "";
        end
        repeat (4) @(negedge clk);
        chk(!out_valid && !out_ok && !out_n && out_imms == 0 && out_immr == 0,
            "R1", "reset state", {out_valid, out_ok, out_n, out_imms, out_immr}, 64'h0);
        rst_n = 1'b1;

        // R2: empty and full operands in both widths (upper half junk in narrow).
        push(1, 64'h0, 1, 0, 0, 0, 0, 0, "R2");
        push(1, '1, 1, 0, 0, 0, 0, 0, "R2");
        push(1, 64'hDEAD_BEEF_0000_0000, 0, 0, 0, 0, 0, 0, "R2");
        push(1, 64'h1234_5678_FFFF_FFFF, 0, 0, 0, 0, 0, 0, "R2");
        push(0, 64'hFFFF_0000_FFFF_0000, 1, 0, 0, 0, 0, 0, "R8");

        // R4/R5/R6: every canonical triple, streamed back to back.
        cnt = 0;
        for (int w = 0; w < 2; w++) begin
            wide = (w == 0);
            for (int len = 1; len <= (wide ? 6 : 5); len++) begin
                int esz;
                esz = 1 << len;
                nb  = (len == 6);
                for (int s = 0; s < esz - 1; s++) begin
                    for (int r = 0; r < esz; r++) begin
                        code = 6'(((~(2 * esz - 1)) & 63) | s);
                        val  = decode(nb, code, 6'(r));
                        if (!wide) val[63:32] = $urandom;
                        push(1, val, wide, 1, nb, code, 6'(r), 0,
                             !wide ? "R5" : (val[0] ? "R6" : "R4"));
                        cnt++;
                        if (cnt % 97 == 0) push(0, {$urandom, $urandom}, wide, 0, 0, 0, 0, 0, "R8");
                    end
                end
            end
        end

        // R7: random operands and legal patterns damaged in one bit.
        for (int i = 0; i < 600; i++) begin
            wide = (i % 2 == 0);
            push_judged({$urandom, $urandom}, wide, "R7");
        end
        for (int i = 0; i < 600; i++) begin
            int len, esz, s, r;
            wide = (i % 3 != 0);
            len  = 1 + ($urandom % (wide ? 6 : 5));
            esz  = 1 << len;
            s    = $urandom % (esz - 1);
            r    = $urandom % esz;
            val  = decode(len == 6, 6'(((~(2 * esz - 1)) & 63) | s), 6'(r));
            val[$urandom % (wide ? 64 : 32)] ^= 1'b1;
            push_judged(val, wide, "R7");
        end
        push(0, 0, 1, 0, 0, 0, 0, 0, "R8");
        push(0, 0, 1, 0, 0, 0, 0, 0, "R8");
        push(0, 0, 1, 0, 0, 0, 0, 0, "R8");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule